// File: doc/BRIEF.md
# LPC I/O Cycle Target

This block is a target on the Low Pin Count bus. It follows the host's 4-bit LAD nibble stream clocked by LCLK and answers only I/O read and I/O write cycles whose 16-bit address equals the programmed address of an enabled channel. There are three channels. Each one has an address input and an enable input, a read-byte input supplied by the register side, and an input-buffer-full flag that a host write sets.

On a write hit the block collects the data byte and answers with a ready sync. In the clock after the sync it issues a one-cycle strobe carrying the channel number and the byte. On a read hit it answers with a ready sync and then drives the channel's byte. Memory, DMA and bus-master cycles, a start field that is not zero, and address misses leave the bus untouched until the host begins the next frame. If LFRAME drops while a cycle is running, the cycle is abandoned and LAD is released in that same clock.

LAD is split into an input, an output and an output enable, so the pad is built outside the block. The write strobe has no ready input. The sync field always reports ready and never inserts wait states, so the register side cannot push back: it must accept the strobe in the cycle it appears.

Top module: `lpc_io_target`

## Requirements
- R1: A cycle starts only when LFRAME is low while the target is idle, or while it is passively waiting after an ignored cycle, and at least one channel is enabled. The start nibble must be 0000. When LFRAME stays low for several clocks, the last nibble seen before LFRAME rises is the one used. With every enable clear, or with a non-zero start nibble, LAD is never driven.
- R2: The nibble in the first clock with LFRAME high is the cycle type: 0000 is an I/O read and 0010 is an I/O write. Any other value is ignored. LAD stays undriven, no strobe is issued and no flag changes.
- R3: The address arrives in the four clocks after the cycle type, most significant nibble first. It is compared with every enabled channel. When several channels hold the same address, the lowest-numbered one wins.
- R4: On an address miss the target never drives LAD, issues no write strobe and leaves every flag unchanged.
- R5: On a write hit, the two data nibbles (least significant first) are followed by two host turnaround clocks. The target then drives a sync of 0000 for one clock. In the next clock, the write strobe is high for exactly one cycle with the channel index and the byte.
- R6: On a read hit, the target drives a sync of 0000 after the two host turnaround clocks. It then drives the channel's byte, least significant nibble first. The byte is taken at the clock that enters the sync.
- R7: After its sync (write) or its data (read), the target drives 1111 for one clock and then releases LAD.
- R8: LFRAME going low during any phase after the cycle type removes the LAD output enable in the same clock, cancels any pending write strobe and flag update, and makes the target wait for LFRAME high before it returns to idle.
- R9: A channel's buffer-full flag is set by that channel's write strobe and cleared by a one-cycle clear pulse. If the set and the clear arrive in the same clock, the set wins. The interrupt output is the OR of the flags masked by the per-channel interrupt enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Bus clock; all fields sampled and driven on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lframe_n | input | 1 | Frame marker from the host, active low |
| lad_i | input | 4 | LAD value seen on the bus |
| lad_o | output | 4 | LAD value driven by the target |
| lad_oe | output | 1 | Output enable for lad_o |
| ch_addr_i | input | 48 | Channel I/O addresses, channel n at bits 16n+15:16n |
| ch_en_i | input | 3 | Channel enables, bit n for channel n |
| rd_data_i | input | 24 | Read bytes, channel n at bits 8n+7:8n |
| wr_valid_o | output | 1 | One-cycle host write strobe |
| wr_chan_o | output | 2 | Channel index of the write |
| wr_data_o | output | 8 | Byte written by the host |
| ibf_clr_i | input | 3 | Per-channel flag clear pulses |
| ibf_ie_i | input | 3 | Per-channel interrupt enables |
| ibf_o | output | 3 | Per-channel input-buffer-full flags |
| irq_o | output | 1 | Masked OR of the flags |

## Verification
Take the clock in which LFRAME first goes low as clock 1. Every response then has a fixed clock. On a write hit the sync is driven after clock 10, the strobe and its flag appear together with the 1111 after clock 11, and LAD is free again after clock 12. On a read hit the sync follows clock 8, the two data nibbles follow clocks 9 and 10, and the 1111 follows clock 11. The abort release is combinational and is checked one nanosecond after LFRAME falls. The bench drives each nibble on the falling edge and samples five nanoseconds after every rising edge. It compares the output enable, LAD, the strobe and the flags against a per-clock expectation derived from the requirements. It also keeps a model of the flags across cycles, including clear pulses that arrive in the same clock as a write.

// File: rtl/lpc_tgt_pkg.sv
`timescale 1ns/1ps
package lpc_tgt_pkg;

  localparam logic [3:0] NIB_START_OK = 4'b0000;
  localparam logic [3:0] CT_IO_RD     = 4'b0000;
  localparam logic [3:0] CT_IO_WR     = 4'b0010;
  localparam logic [3:0] NIB_READY    = 4'b0000;
  localparam logic [3:0] NIB_IDLE     = 4'b1111;
  localparam int         TAR_CYC      = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_WDATA,
    ST_HTAR,
    ST_SYNC,
    ST_RDATA,
    ST_TTAR,
    ST_SKIP,
    ST_ABORT
  } seq_state_e;

endpackage

// File: rtl/lpc_tgt_decode.sv
`timescale 1ns/1ps
module lpc_tgt_decode #(
  parameter int AW  = 16,
  parameter int NCH = 3
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [NCH*AW-1:0] ch_addr_i,
  input  logic [NCH-1:0]    ch_en_i,
  output logic              hit_o,
  output logic [$clog2(NCH)-1:0] idx_o
);
  localparam int CW = $clog2(NCH);

  logic [NCH-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_cmp
      assign match[g] = ch_en_i[g] && (ch_addr_i[g*AW +: AW] == addr_i);
    end
  endgenerate

  // scan downward so the lowest matching channel is the one left standing
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = CW'(i);
      end
    end
  end

  always_comb begin
    if (hit_o) begin
      AST_HIT_ENABLED: assert (ch_en_i[idx_o]); // R3
    end
  end

endmodule

// File: rtl/lpc_tgt_flags.sv
`timescale 1ns/1ps
module lpc_tgt_flags #(
  parameter int NCH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_i,
  input  logic [$clog2(NCH)-1:0] chan_i,
  input  logic [NCH-1:0]         clr_i,
  input  logic [NCH-1:0]         ie_i,
  output logic [NCH-1:0]         ibf_o,
  output logic                   irq_o
);
  logic [NCH-1:0] ibf_q;
  logic [NCH-1:0] set_v;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_flag
      assign set_v[g] = commit_i && (chan_i == ($clog2(NCH))'(g));

      always_ff @(posedge clk) begin
        if (!rst_n)          ibf_q[g] <= 1'b0;
        else if (set_v[g])   ibf_q[g] <= 1'b1;
        else if (clr_i[g])   ibf_q[g] <= 1'b0;
      end

      AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_v[g] |=> ibf_q[g]); // R9
      AST_IBF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[g] && !set_v[g]) |=> !ibf_q[g]); // R9
    end
  endgenerate

  assign ibf_o = ibf_q;
  assign irq_o = |(ibf_q & ie_i);

  AST_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_v)); // R9

endmodule

// File: rtl/lpc_tgt_seq.sv
`timescale 1ns/1ps
module lpc_tgt_seq
  import lpc_tgt_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int NCH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lframe_n,
  input  logic [3:0]             lad_i,
  input  logic                   any_en_i,
  input  logic                   hit_i,
  input  logic [$clog2(NCH)-1:0] hit_idx_i,
  input  logic [NCH*DW-1:0]      rd_data_i,
  output logic [AW-1:0]          cand_addr_o,
  output logic [3:0]             lad_o,
  output logic                   lad_oe,
  output logic                   commit_o,
  output logic [$clog2(NCH)-1:0] chan_o,
  output logic                   wr_valid_o,
  output logic [$clog2(NCH)-1:0] wr_chan_o,
  output logic [DW-1:0]          wr_data_o
);
  localparam int CW       = $clog2(NCH);
  localparam int ADDR_NIB = AW / 4;
  localparam int DATA_NIB = DW / 4;
  localparam int CNTW     = $clog2(ADDR_NIB + 1);

  seq_state_e        st_q;
  logic [CNTW-1:0]   cnt_q;
  logic [3:0]        stnib_q;
  logic              is_wr_q;
  logic [AW-5:0]     ash_q;
  logic [CW-1:0]     ch_q;
  logic [DW-1:0]     wd_q;
  logic [DW-1:0]     rd_q;
  logic [DW-1:0]     rd_sel;
  logic              wv_q;
  logic [CW-1:0]     wch_q;
  logic [DW-1:0]     wdo_q;
  logic              oe_int;
  logic              active;
  logic              abort;
  logic              last_addr, last_dat, last_tar;

  assign active = (st_q == ST_ADDR) || (st_q == ST_WDATA) || (st_q == ST_HTAR) ||
                  (st_q == ST_SYNC) || (st_q == ST_RDATA) || (st_q == ST_TTAR);
  assign abort     = active && !lframe_n;
  assign last_addr = (cnt_q == CNTW'(ADDR_NIB - 1));
  assign last_dat  = (cnt_q == CNTW'(DATA_NIB - 1));
  assign last_tar  = (cnt_q == CNTW'(TAR_CYC - 1));

  assign cand_addr_o = {ash_q, lad_i};
  assign commit_o    = (st_q == ST_SYNC) && is_wr_q && lframe_n;
  assign chan_o      = ch_q;

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_q == CW'(i)) rd_sel = rd_data_i[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      stnib_q <= NIB_IDLE;
      is_wr_q <= 1'b0;
      ash_q   <= '0;
      ch_q    <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      wv_q    <= 1'b0;
      wch_q   <= '0;
      wdo_q   <= '0;
    end else begin
      wv_q <= commit_o;
      if (commit_o) begin
        wch_q <= ch_q;
        wdo_q <= wd_q;
      end
      if (abort) begin
        st_q  <= ST_ABORT;
        cnt_q <= '0;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (!lframe_n && any_en_i) begin
              st_q    <= ST_START;
              stnib_q <= lad_i;
            end
          end
          ST_START: begin
            if (!lframe_n) begin
              stnib_q <= lad_i;
            end else if (stnib_q == NIB_START_OK &&
                         (lad_i == CT_IO_RD || lad_i == CT_IO_WR)) begin
              st_q    <= ST_ADDR;
              cnt_q   <= '0;
              is_wr_q <= (lad_i == CT_IO_WR);
            end else begin
              st_q <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            ash_q <= cand_addr_o[AW-5:0];
            if (last_addr) begin
              cnt_q <= '0;
              if (hit_i) begin
                ch_q <= hit_idx_i;
                st_q <= is_wr_q ? ST_WDATA : ST_HTAR;
              end else begin
                st_q <= ST_SKIP;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WDATA: begin
            wd_q <= {lad_i, wd_q[DW-1:4]};
            if (last_dat) begin
              cnt_q <= '0;
              st_q  <= ST_HTAR;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_HTAR: begin
            if (last_tar) begin
              cnt_q <= '0;
              st_q  <= ST_SYNC;
              rd_q  <= rd_sel;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_SYNC: begin
            st_q <= is_wr_q ? ST_TTAR : ST_RDATA;
          end
          ST_RDATA: begin
            rd_q <= rd_q >> 4;
            if (last_dat) begin
              cnt_q <= '0;
              st_q  <= ST_TTAR;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_TTAR: begin
            if (last_tar) begin
              cnt_q <= '0;
              st_q  <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_SKIP: begin
            if (!lframe_n) begin
              if (any_en_i) begin
                st_q    <= ST_START;
                stnib_q <= lad_i;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ABORT: begin
            if (lframe_n) st_q <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    oe_int = 1'b0;
    lad_o  = NIB_IDLE;
    case (st_q)
      ST_SYNC: begin
        oe_int = 1'b1;
        lad_o  = NIB_READY;
      end
      ST_RDATA: begin
        oe_int = 1'b1;
        lad_o  = rd_q[3:0];
      end
      ST_TTAR: begin
        oe_int = (cnt_q == '0);
        lad_o  = NIB_IDLE;
      end
      default: begin
        oe_int = 1'b0;
        lad_o  = NIB_IDLE;
      end
    endcase
  end

  // the frame marker gates the enable without waiting for a clock edge
  assign lad_oe = oe_int && lframe_n;

  assign wr_valid_o = wv_q;
  assign wr_chan_o  = wch_q;
  assign wr_data_o  = wdo_q;

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !lframe_n) |=> (st_q == ST_ABORT) && !oe_int); // R8
  AST_START_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && $past(st_q) != ST_START) |-> $past(!lframe_n)); // R1
  AST_SYNC_AFTER_TAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_int) |-> (st_q == ST_SYNC) && ($past(st_q) == ST_HTAR)); // R5
  AST_WR_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q |-> ($past(st_q) == ST_SYNC) && $past(is_wr_q)); // R5
  AST_MISS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && last_addr && !hit_i && lframe_n) |=> (st_q == ST_SKIP)); // R4
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |=> !wv_q); // R2

endmodule

// File: rtl/lpc_io_target.sv
`timescale 1ns/1ps
module lpc_io_target #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int NCH = 3
) (
  input  logic                   lclk,
  input  logic                   rst_n,
  input  logic                   lframe_n,
  input  logic [3:0]             lad_i,
  output logic [3:0]             lad_o,
  output logic                   lad_oe,
  input  logic [NCH*AW-1:0]      ch_addr_i,
  input  logic [NCH-1:0]         ch_en_i,
  input  logic [NCH*DW-1:0]      rd_data_i,
  output logic                   wr_valid_o,
  output logic [$clog2(NCH)-1:0] wr_chan_o,
  output logic [DW-1:0]          wr_data_o,
  input  logic [NCH-1:0]         ibf_clr_i,
  input  logic [NCH-1:0]         ibf_ie_i,
  output logic [NCH-1:0]         ibf_o,
  output logic                   irq_o
);
  localparam int CW = $clog2(NCH);

  logic [AW-1:0] cand_addr;
  logic          hit;
  logic [CW-1:0] hit_idx;
  logic          commit;
  logic [CW-1:0] chan;

  lpc_tgt_decode #(.AW(AW), .NCH(NCH)) u_decode (
    .addr_i    (cand_addr),
    .ch_addr_i (ch_addr_i),
    .ch_en_i   (ch_en_i),
    .hit_o     (hit),
    .idx_o     (hit_idx)
  );

  lpc_tgt_seq #(.AW(AW), .DW(DW), .NCH(NCH)) u_seq (
    .clk         (lclk),
    .rst_n       (rst_n),
    .lframe_n    (lframe_n),
    .lad_i       (lad_i),
    .any_en_i    (|ch_en_i),
    .hit_i       (hit),
    .hit_idx_i   (hit_idx),
    .rd_data_i   (rd_data_i),
    .cand_addr_o (cand_addr),
    .lad_o       (lad_o),
    .lad_oe      (lad_oe),
    .commit_o    (commit),
    .chan_o      (chan),
    .wr_valid_o  (wr_valid_o),
    .wr_chan_o   (wr_chan_o),
    .wr_data_o   (wr_data_o)
  );

  lpc_tgt_flags #(.NCH(NCH)) u_flags (
    .clk      (lclk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .chan_i   (chan),
    .clr_i    (ibf_clr_i),
    .ie_i     (ibf_ie_i),
    .ibf_o    (ibf_o),
    .irq_o    (irq_o)
  );

endmodule

// File: tb/lpc_io_target_tb_top.sv
`timescale 1ns/1ps
module lpc_io_target_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lframe_n = 1'b1;
  logic [3:0]  host_lad = 4'hF;
  logic        host_oe = 1'b0;
  logic [3:0]  lad_bus;
  logic [3:0]  lad_o;
  logic        lad_oe;
  logic [47:0] ch_addr = '0;
  logic [2:0]  ch_en = '0;
  logic [23:0] rd_data = '0;
  logic        wr_valid;
  logic [1:0]  wr_chan;
  logic [7:0]  wr_data;
  logic [2:0]  ibf_clr = '0;
  logic [2:0]  ibf_ie = '0;
  logic [2:0]  ibf;
  logic        irq;

  logic [2:0]  exp_ibf = '0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  assign lad_bus = lad_oe ? lad_o : (host_oe ? host_lad : 4'hF);

  lpc_io_target dut_i (
    .lclk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_i(lad_bus),
    .lad_o(lad_o), .lad_oe(lad_oe), .ch_addr_i(ch_addr), .ch_en_i(ch_en),
    .rd_data_i(rd_data), .wr_valid_o(wr_valid), .wr_chan_o(wr_chan),
    .wr_data_o(wr_data), .ibf_clr_i(ibf_clr), .ibf_ie_i(ibf_ie),
    .ibf_o(ibf), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int exp_chan(input logic [15:0] a);
    for (int i = 0; i < 3; i++)
      if (ch_en[i] && ch_addr[i*16 +: 16] == a) return i;
    return -1;
  endfunction

  task automatic idle_step();
    @(negedge clk);
    lframe_n = 1'b1; host_oe = 1'b0; host_lad = 4'hF;
    @(posedge clk); #5;
  endtask

  // one full frame; abort_s = clock index at which LFRAME is forced low (0 = none)
  task automatic run_io(input logic [15:0] a, input logic [7:0] d, input logic [3:0] ct,
                        input logic [3:0] sn, input int abort_s, input logic [2:0] clr_c,
                        input string tag);
    int       ch;
    int       hch;
    bit       wr;
    bit       aborted;
    bit       e_oe, e_wv;
    logic [3:0] e_lad;
    logic [7:0] rexp;
    logic     lf, hd;
    logic [3:0] hv;
    ch  = exp_chan(a);
    wr  = (ct == 4'b0010);
    hch = (sn == 4'b0000 && (ct == 4'b0000 || ct == 4'b0010)) ? ch : -1;
    rexp = (hch >= 0) ? rd_data[hch*8 +: 8] : 8'h00;
    aborted = 1'b0;
    for (int s = 1; s <= 13; s++) begin
      lf = 1'b1; hv = 4'hF; hd = 1'b0;
      if (s == 1) begin lf = 1'b0; hv = sn; hd = 1'b1; end
      else if (s == 2) begin hv = ct; hd = 1'b1; end
      else if (s <= 6) begin hv = a[(6-s)*4 +: 4]; hd = 1'b1; end
      else if (wr && s == 7) begin hv = d[3:0]; hd = 1'b1; end
      else if (wr && s == 8) begin hv = d[7:4]; hd = 1'b1; end
      else if ((wr && s == 9) || (!wr && s == 7)) begin hv = 4'hF; hd = 1'b1; end
      if (s == abort_s) begin lf = 1'b0; hv = 4'hF; hd = 1'b1; end
      @(negedge clk);
      lframe_n = lf; host_lad = hv; host_oe = hd;
      ibf_clr = (s == 11) ? clr_c : 3'b000;
      if (s == abort_s) begin
        aborted = 1'b1;
        #1 chk(lad_oe == 1'b0, "R8 release on LFRAME low", lad_oe, 0);
      end
      @(posedge clk); #5;
      e_oe = 1'b0; e_lad = 4'hF; e_wv = 1'b0;
      if (!aborted && hch >= 0) begin
        if (wr) begin
          if (s == 10) begin e_oe = 1'b1; e_lad = 4'h0; end
          if (s == 11) begin e_oe = 1'b1; e_lad = 4'hF; e_wv = 1'b1; end
        end else begin
          if (s == 8)  begin e_oe = 1'b1; e_lad = 4'h0; end
          if (s == 9)  begin e_oe = 1'b1; e_lad = rexp[3:0]; end
          if (s == 10) begin e_oe = 1'b1; e_lad = rexp[7:4]; end
          if (s == 11) begin e_oe = 1'b1; e_lad = 4'hF; end
        end
      end
      chk(!(lad_oe && host_oe), "R8 no bus contention", {lad_oe, host_oe}, 0);
      chk(lad_oe == e_oe, tag, lad_oe, e_oe);
      if (e_oe) chk(lad_o == e_lad, (s == 11) ? "R7 target turnaround" : (wr ? "R5" : "R6"), lad_o, e_lad);
      chk(wr_valid == e_wv, wr ? "R5 strobe" : tag, wr_valid, e_wv);
      if (e_wv) begin
        chk(wr_chan == hch[1:0], "R5 channel", wr_chan, hch);
        chk(wr_data == d, "R5 data", wr_data, d);
      end
      if (s == 11) begin
        exp_ibf = exp_ibf & ~clr_c;
        if (e_wv) exp_ibf[hch] = 1'b1;
        chk(ibf == exp_ibf, "R9 flag update", ibf, exp_ibf);
      end
    end
    ibf_clr = 3'b000;
    idle_step();
    chk(ibf == exp_ibf, (hch < 0) ? "R4 flags untouched" : "R9 flags", ibf, exp_ibf);
    chk(irq == |(exp_ibf & ibf_ie), "R9 irq", irq, |(exp_ibf & ibf_ie));
  endtask

  task automatic clear_flags(input logic [2:0] m);
    @(negedge clk);
    ibf_clr = m;
    @(posedge clk); #5;
    ibf_clr = 3'b000;
    exp_ibf = exp_ibf & ~m;
    chk(ibf == exp_ibf, "R9 clear", ibf, exp_ibf);
    chk(irq == |(exp_ibf & ibf_ie), "R9 irq after clear", irq, |(exp_ibf & ibf_ie));
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] ra;
    logic [3:0]  rct;
    int          rab;
    void'($urandom(32'h51C0_0A7E));
    ch_addr = {16'h0CA4, 16'h0062, 16'h0CA2};
    ch_en   = 3'b111;
    rd_data = {8'h3C, 8'h96, 8'h5A};
    repeat (3) @(posedge clk);
    #5;
    chk(lad_oe == 1'b0, "R1 reset enable", lad_oe, 0);
    chk(wr_valid == 1'b0, "R5 reset strobe", wr_valid, 0);
    chk(ibf == 3'b000, "R9 reset flags", ibf, 0);
    chk(irq == 1'b0, "R9 reset irq", irq, 0);
    @(negedge clk); rst_n = 1'b1;
    idle_step();

    ibf_ie = 3'b100;
    run_io(16'h0CA2, 8'hA5, 4'b0010, 4'h0, 0, 3'b000, "R5 write ch0");
    run_io(16'h0062, 8'h00, 4'b0000, 4'h0, 0, 3'b000, "R6 read ch1");
    run_io(16'h0CA4, 8'h7E, 4'b0010, 4'h0, 0, 3'b000, "R5 write ch2 irq");
    run_io(16'h0CA3, 8'h11, 4'b0010, 4'h0, 0, 3'b000, "R4 write miss");
    run_io(16'h1CA2, 8'h00, 4'b0000, 4'h0, 0, 3'b000, "R4 read miss");
    run_io(16'h0CA2, 8'h22, 4'b0100, 4'h0, 0, 3'b000, "R2 memory read ignored");
    run_io(16'h0CA2, 8'h33, 4'b0110, 4'h0, 0, 3'b000, "R2 memory write ignored");
    run_io(16'h0062, 8'h44, 4'b1000, 4'h0, 0, 3'b000, "R2 dma ignored");
    run_io(16'h0CA2, 8'h55, 4'b0010, 4'h3, 0, 3'b000, "R1 non-zero start ignored");
    // LFRAME held low for an extra clock with 1111 first; the later 0000 counts
    @(negedge clk); lframe_n = 1'b0; host_lad = 4'hF; host_oe = 1'b1;
    @(posedge clk);
    run_io(16'h0062, 8'h00, 4'b0000, 4'h0, 0, 3'b000, "R1 long start field");
    clear_flags(3'b101);

    ch_en = 3'b110;
    run_io(16'h0CA2, 8'h66, 4'b0010, 4'h0, 0, 3'b000, "R3 disabled channel misses");
    ch_en = 3'b000;
    run_io(16'h0062, 8'h77, 4'b0010, 4'h0, 0, 3'b000, "R1 all disabled");
    ch_en = 3'b111;
    ch_addr[47:32] = 16'h0062;
    run_io(16'h0062, 8'h88, 4'b0010, 4'h0, 0, 3'b000, "R3 lowest channel wins");
    ch_addr[47:32] = 16'h0CA4;

    run_io(16'h0CA2, 8'h99, 4'b0010, 4'h0, 9, 3'b000, "R8 abort in host turnaround");
    run_io(16'h0062, 8'h00, 4'b0000, 4'h0, 9, 3'b000, "R8 abort while driving");
    run_io(16'h0CA4, 8'hAB, 4'b0010, 4'h0, 4, 3'b000, "R8 abort in address");
    run_io(16'h0CA4, 8'h00, 4'b0000, 4'h0, 0, 3'b000, "R6 read after abort");
    clear_flags(3'b111);
    run_io(16'h0062, 8'hCD, 4'b0010, 4'h0, 0, 3'b010, "R9 set beats clear");
    clear_flags(3'b010);

    for (int n = 0; n < 160; n++) begin
      rd_data = {$urandom} & 24'hFFFFFF;
      ibf_ie  = 3'($urandom);
      ch_en   = (($urandom % 8) == 0) ? 3'($urandom) : 3'b111;
      case ($urandom % 4)
        0: ra = ch_addr[15:0];
        1: ra = ch_addr[31:16];
        2: ra = ch_addr[47:32];
        default: ra = 16'($urandom);
      endcase
      case ($urandom % 8)
        0: rct = 4'($urandom);
        1, 2, 3: rct = 4'b0000;
        default: rct = 4'b0010;
      endcase
      rab = (($urandom % 6) == 0) ? int'(3 + ($urandom % 11)) : 0;
      run_io(ra, 8'($urandom), rct, (($urandom % 16) == 0) ? 4'h1 : 4'h0, rab,
             (($urandom % 4) == 0) ? 3'($urandom) : 3'b000, "R3 random frame");
      if (($urandom % 5) == 0) clear_flags(3'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule